// File: doc/BRIEF.md
# Zone-Weighted Luminance Meter

This block measures the brightness of one video frame for an exposure loop. The active picture is cut into a square grid of rectangular zones: eight by eight zones of 44 pixels by 36 lines by default, which covers 352 by 288 pixels. Each accepted pixel's luminance is multiplied by a weight of k/4, with k in {2, 3, 4, 5}. The weight belongs to the zone the pixel falls in and is taken from one of four fixed weighting maps. When the last pixel of the grid arrives, the weighted sum is divided by the total weight. The result is a weighted mean luminance in unsigned 8.4 fixed point: 12 bits, with four fraction bits.

The upstream pipeline feeds the block with a frame-start strobe, a line-start strobe, a pixel-valid strobe and the pixel luminance. The 2-bit map select is captured once per frame. The exposure decision that consumes the result lies outside this block.

Top module: `lum_zone_meter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `meas` is 0 and `meas_valid` is 0.
- R2: Accepted pixels are assigned to zones in raster order, ZONE_W pixels per zone column and ZONE_H lines per zone row. Pixels whose column index is GRID*ZONE_W or more, or whose line index is GRID*ZONE_H or more, are ignored.
- R3: The zone weight k depends on the captured map code. Code 2'b10 gives k=4 for every zone. Code 2'b11 gives k=2 for zone rows below GRID/4, k=4 for the remaining rows below GRID/2, and k=5 for the lower half. Code 2'b00 gives k=5 in the central block, where both zone row and zone column lie in [GRID/4, 3*GRID/4); outside that block it gives k=2 on the outer zone ring and k=4 elsewhere. Code 2'b01 gives k=5 in the same central block, k=2 for the remaining zones in rows below GRID/4, and k=3 elsewhere.
- R4: The result equals floor(16 * sum(k*Y) / sum(k)), taken over all accepted pixels of the frame and clamped to 4095.
- R5: Each completed grid produces exactly one single-cycle `meas_valid` pulse, within 60 cycles of the last grid pixel. `meas` holds its value between pulses.
- R6: `map_sel` is captured only in a `frame_start` cycle. A change later in the frame has no effect on that frame's result.
- R7: `frame_start` discards any partial accumulation and restarts the position counters. A pixel presented in the same cycle as `frame_start` or `line_start` is dropped.
- R8: `line_start` moves to the next line only if at least one valid pixel arrived since the last sync. A `line_start` straight after `frame_start` therefore does not skip line 0.
- R9: Cycles with `pix_valid` low neither advance the position nor change the sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle strobe that begins a frame |
| line_start | input | 1 | One-cycle strobe that begins a new line |
| pix_valid | input | 1 | Pixel strobe |
| pix_luma | input | PIX_W | Pixel luminance |
| map_sel | input | 2 | Weighting map code, captured at frame start |
| meas | output | OUT_W | Weighted mean luminance, 8.4 fixed point |
| meas_valid | output | 1 | One-cycle pulse when `meas` is updated |

## Verification
The bench uses a small grid and shapes its frames so that each weighting map gives a distinct result. A wrong zone boundary or a swapped map would therefore move the answer: for example, a bright lower half reads 2550 under the lower-weighted map and 2040 under the flat one.

Several corner cases are driven on purpose:
- A map switch in mid-frame would show up as a flat-map result if the select were not captured at frame start.
- Bright pixels past the right edge would raise the mean if out-of-grid pixels were counted.
- A leading line strobe would lose a line and withhold the result if it were counted as a line.
- Bright pixels riding on sync strobes, and an aborted half frame, would leak into the next result if syncs did not clear the sums and drop coincident pixels.

// File: rtl/lum_meter_pkg.sv
package lum_meter_pkg;

  typedef enum logic [1:0] {
    MAP_CTR_RING = 2'b00,
    MAP_CTR_TOP  = 2'b01,
    MAP_FLAT     = 2'b10,
    MAP_LOWER    = 2'b11
  } lum_map_e;

  localparam int unsigned WGT_W   = 3;
  localparam int unsigned WGT_MAX = 5;

  // Weight numerator k (weight = k/4) for a zone under a given map.
  function automatic logic [WGT_W-1:0] zone_weight(input lum_map_e sel,
                                                   input int unsigned zr,
                                                   input int unsigned zc,
                                                   input int unsigned grid);
    logic centre;
    logic ring;
    logic [WGT_W-1:0] k;
    centre = (zr >= grid / 4) && (zr < (3 * grid) / 4) &&
             (zc >= grid / 4) && (zc < (3 * grid) / 4);
    ring   = (zr == 0) || (zc == 0) || (zr == grid - 1) || (zc == grid - 1);
    case (sel)
      MAP_FLAT:  k = 3'd4;
      MAP_LOWER: begin
        if (zr < grid / 4)      k = 3'd2;
        else if (zr < grid / 2) k = 3'd4;
        else                    k = 3'd5;
      end
      MAP_CTR_RING: begin
        if (centre)    k = 3'd5;
        else if (ring) k = 3'd2;
        else           k = 3'd4;
      end
      default: begin
        if (centre)             k = 3'd5;
        else if (zr < grid / 4) k = 3'd2;
        else                    k = 3'd3;
      end
    endcase
    return k;
  endfunction

endpackage

// File: rtl/lum_zone_track.sv
module lum_zone_track #(
  parameter int ZONE_W = 44,
  parameter int ZONE_H = 36,
  parameter int GRID   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_start,
  input  logic                    line_start,
  input  logic                    pix_valid,
  output logic [$clog2(GRID)-1:0] zone_r,
  output logic [$clog2(GRID)-1:0] zone_c,
  output logic                    take,
  output logic                    last
);
  localparam int ZC_W = $clog2(GRID);
  localparam int SX_W = (ZONE_W > 1) ? $clog2(ZONE_W) : 1;
  localparam int SY_W = (ZONE_H > 1) ? $clog2(ZONE_H) : 1;
  localparam logic [SX_W-1:0] SX_LAST = SX_W'(ZONE_W - 1);
  localparam logic [SY_W-1:0] SY_LAST = SY_W'(ZONE_H - 1);
  localparam logic [ZC_W-1:0] ZC_LAST = ZC_W'(GRID - 1);

  logic [SX_W-1:0] sub_x;
  logic [SY_W-1:0] sub_y;
  logic            col_full;
  logic            row_full;
  logic            line_used;

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      sub_x     <= '0;
      sub_y     <= '0;
      zone_c    <= '0;
      zone_r    <= '0;
      col_full  <= 1'b0;
      row_full  <= 1'b0;
      line_used <= 1'b0;
    end else if (line_start) begin
      if (line_used) begin
        sub_x     <= '0;
        zone_c    <= '0;
        col_full  <= 1'b0;
        line_used <= 1'b0;
        if (!row_full) begin
          if (sub_y == SY_LAST) begin
            sub_y <= '0;
            if (zone_r == ZC_LAST) row_full <= 1'b1;
            else                   zone_r   <= zone_r + 1'b1;
          end else begin
            sub_y <= sub_y + 1'b1;
          end
        end
      end
    end else if (pix_valid) begin
      line_used <= 1'b1;
      if (!col_full) begin
        if (sub_x == SX_LAST) begin
          sub_x <= '0;
          if (zone_c == ZC_LAST) col_full <= 1'b1;
          else                   zone_c   <= zone_c + 1'b1;
        end else begin
          sub_x <= sub_x + 1'b1;
        end
      end
    end
  end

  always_comb begin
    take = pix_valid && !frame_start && !line_start && !col_full && !row_full;
    last = take && (sub_x == SX_LAST) && (zone_c == ZC_LAST) &&
           (sub_y == SY_LAST) && (zone_r == ZC_LAST);
  end

endmodule

// File: rtl/lum_wsum_acc.sv
module lum_wsum_acc #(
  parameter int PIX_W = 8,
  parameter int WGT_W = 3,
  parameter int ACC_W = 27,
  parameter int WS_W  = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             take,
  input  logic             last,
  input  logic [PIX_W-1:0] luma,
  input  logic [WGT_W-1:0] k,
  output logic             fin_start,
  output logic [ACC_W-1:0] fin_acc,
  output logic [WS_W-1:0]  fin_ws
);
  localparam int PROD_W = PIX_W + WGT_W;

  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  acc_nx;
  logic [WS_W-1:0]   ws;
  logic [WS_W-1:0]   ws_nx;

  always_comb begin
    prod   = PROD_W'(luma) * PROD_W'(k);
    acc_nx = acc + ACC_W'(prod);
    ws_nx  = ws + WS_W'(k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      ws        <= '0;
      fin_start <= 1'b0;
      fin_acc   <= '0;
      fin_ws    <= '0;
    end else begin
      fin_start <= take && last;
      if (clear) begin
        acc <= '0;
        ws  <= '0;
      end else if (take) begin
        acc <= acc_nx;
        ws  <= ws_nx;
      end
      if (take && last) begin
        fin_acc <= acc_nx;
        fin_ws  <= ws_nx;
      end
    end
  end

endmodule

// File: rtl/lum_div.sv
module lum_div #(
  parameter int NW    = 31,
  parameter int DW    = 19,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NW-1:0]    num,
  input  logic [DW-1:0]    den,
  output logic [OUT_W-1:0] res,
  output logic             res_valid
);
  localparam int CNT_W = $clog2(NW + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [NW-1:0]    nreg;
  logic [DW-1:0]    dreg;
  logic [DW-1:0]    rem;
  logic [NW-1:0]    q;
  logic [DW:0]      trial;
  logic [DW:0]      diff;
  logic             ge;
  logic [DW-1:0]    rem_nx;
  logic [NW-1:0]    q_nx;
  logic             over;
  logic [OUT_W-1:0] clamped;

  always_comb begin
    trial  = {rem, nreg[NW-1]};
    ge     = trial >= {1'b0, dreg};
    diff   = trial - {1'b0, dreg};
    rem_nx = ge ? diff[DW-1:0] : trial[DW-1:0];
    q_nx   = {q[NW-2:0], ge};
  end

  generate
    if (NW > OUT_W) begin : g_clamp
      assign over = |q_nx[NW-1:OUT_W];
    end else begin : g_noclamp
      assign over = 1'b0;
    end
  endgenerate

  assign clamped = over ? {OUT_W{1'b1}} : q_nx[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      nreg      <= '0;
      dreg      <= '0;
      rem       <= '0;
      q         <= '0;
      res       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(NW);
        nreg <= num;
        dreg <= den;
        rem  <= '0;
        q    <= '0;
      end else if (busy) begin
        rem  <= rem_nx;
        q    <= q_nx;
        nreg <= nreg << 1;
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy      <= 1'b0;
          res       <= clamped;
          res_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lum_zone_meter.sv
module lum_zone_meter #(
  parameter int PIX_W  = 8,
  parameter int ZONE_W = 44,
  parameter int ZONE_H = 36,
  parameter int GRID   = 8,
  parameter int FRAC   = 4,
  parameter int OUT_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             line_start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_luma,
  input  logic [1:0]       map_sel,
  output logic [OUT_W-1:0] meas,
  output logic             meas_valid
);
  import lum_meter_pkg::*;

  localparam int ZC_W  = $clog2(GRID);
  localparam int NPIX  = GRID * GRID * ZONE_W * ZONE_H;
  localparam int ACC_W = $clog2(NPIX * ((2 ** PIX_W) - 1) * WGT_MAX + 1);
  localparam int WS_W  = $clog2(NPIX * WGT_MAX + 1);
  localparam int NW    = ACC_W + FRAC;

  logic [ZC_W-1:0]  zone_r;
  logic [ZC_W-1:0]  zone_c;
  logic             take;
  logic             frame_end;
  logic             last;
  lum_map_e         map_q;
  logic [WGT_W-1:0] k;
  logic             fin_start;
  logic [ACC_W-1:0] fin_acc;
  logic [WS_W-1:0]  fin_ws;
  logic [NW-1:0]    num;

  lum_zone_track #(.ZONE_W(ZONE_W), .ZONE_H(ZONE_H), .GRID(GRID)) track_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .pix_valid(pix_valid), .zone_r(zone_r), .zone_c(zone_c),
    .take(take), .last(last)
  );

  assign frame_end = take && last;

  always_ff @(posedge clk) begin
    if (rst)              map_q <= MAP_CTR_RING;
    else if (frame_start) map_q <= lum_map_e'(map_sel);
  end

  assign k = zone_weight(map_q, 32'(zone_r), 32'(zone_c), 32'(GRID));

  lum_wsum_acc #(.PIX_W(PIX_W), .WGT_W(WGT_W), .ACC_W(ACC_W), .WS_W(WS_W)) acc_i (
    .clk(clk), .rst(rst), .clear(frame_start), .take(take), .last(last),
    .luma(pix_luma), .k(k), .fin_start(fin_start), .fin_acc(fin_acc),
    .fin_ws(fin_ws)
  );

  assign num = {fin_acc, {FRAC{1'b0}}};

  lum_div #(.NW(NW), .DW(WS_W), .OUT_W(OUT_W)) div_i (
    .clk(clk), .rst(rst), .start(fin_start), .num(num), .den(fin_ws),
    .res(meas), .res_valid(meas_valid)
  );

endmodule

// File: rtl/lum_zone_meter_chk.sv
module lum_zone_meter_chk #(
  parameter int PIX_W   = 8,
  parameter int FRAC    = 4,
  parameter int OUT_W   = 12,
  parameter int LAT_MAX = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_end,
  input logic [OUT_W-1:0] meas,
  input logic             meas_valid
);
  localparam int MEAS_MAX = ((2 ** PIX_W) - 1) * (2 ** FRAC);

  logic        pend;
  logic [15:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      wait_cnt <= '0;
    end else if (frame_end) begin
      pend     <= 1'b1;
      wait_cnt <= '0;
    end else if (meas_valid) begin
      pend     <= 1'b0;
      wait_cnt <= '0;
    end else if (pend && wait_cnt != 16'hFFFF) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (meas == '0 && !meas_valid));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    meas_valid |=> !meas_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !meas_valid |-> $stable(meas));

  a_r5_after_frame: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> pend);

  a_r5_bounded: assert property (@(posedge clk) disable iff (rst)
    pend |-> (wait_cnt <= 16'(LAT_MAX)));

  a_r4_range: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> (32'(meas) <= MEAS_MAX));

endmodule

bind lum_zone_meter lum_zone_meter_chk chk_i (
  .clk(clk), .rst(rst), .frame_end(frame_end), .meas(meas),
  .meas_valid(meas_valid)
);

// File: tb/lum_zone_meter_tb.sv
module lum_zone_meter_tb_top;
  localparam int CLK_P = 10;
  localparam int ZW = 2;
  localparam int ZH = 2;
  localparam int G  = 8;
  localparam int GS = G * ZW;
  localparam int NV = 8;
  localparam logic [12:0] USE_MODEL = 13'd8191;
  // {map[1:0], kind[2:0], prm[7:0], expected[12:0]}
  localparam logic [25:0] VEC [NV] = '{
    {2'b10, 3'd0, 8'd100, 13'd1600},
    {2'b11, 3'd0, 8'd255, 13'd4080},
    {2'b00, 3'd0, 8'd0,   13'd0},
    {2'b11, 3'd2, 8'd0,   13'd2550},
    {2'b10, 3'd2, 8'd0,   13'd2040},
    {2'b00, 3'd3, 8'd0,   13'd1511},
    {2'b01, 3'd3, 8'd0,   13'd1569},
    {2'b01, 3'd1, 8'd17,  USE_MODEL}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic       line_start = 1'b0;
  logic       pix_valid = 1'b0;
  logic [7:0] pix_luma = '0;
  logic [1:0] map_sel = '0;
  logic [11:0] meas;
  logic       meas_valid;

  int    checks = 0;
  int    fails = 0;
  bit    finished = 1'b0;
  longint msum;
  longint mw;

  always #(CLK_P / 2) clk = ~clk;

  lum_zone_meter #(.ZONE_W(ZW), .ZONE_H(ZH), .GRID(G)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .pix_valid(pix_valid), .pix_luma(pix_luma), .map_sel(map_sel),
    .meas(meas), .meas_valid(meas_valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wt(input int sel, input int zr, input int zc);
    bit mid;
    mid = zr >= 2 && zr < 6 && zc >= 2 && zc < 6;
    case (sel)
      2: return 4;
      3: return (zr < 2) ? 2 : (zr < 4) ? 4 : 5;
      0: return mid ? 5 : (zr == 0 || zc == 0 || zr == 7 || zc == 7) ? 2 : 4;
      default: return mid ? 5 : (zr < 2) ? 2 : 3;
    endcase
  endfunction

  function automatic int luma_of(input int kind, input int prm, input int x, input int y);
    case (kind)
      0: return prm;
      1: return (x * 9 + y * 5 + prm) % 256;
      2: return (y >= GS / 2) ? 255 : 0;
      default: return (x >= 4 && x < 12 && y >= 4 && y < 12) ? 255 : 0;
    endcase
  endfunction

  task automatic drive_frame(input int sel, input int kind, input int prm, input int extra,
                             input bit lead_ls, input bit mid_sw, input bit gaps,
                             input bit sync_pix);
    int lv;
    int w;
    msum = 0;
    mw = 0;
    map_sel = 2'(sel);
    frame_start = 1'b1;
    pix_valid = sync_pix;
    pix_luma = 8'hFF;
    @(negedge clk);
    frame_start = 1'b0;
    pix_valid = 1'b0;
    if (lead_ls) begin
      line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
    end
    for (int y = 0; y < GS; y++) begin
      if (y > 0) begin
        line_start = 1'b1;
        pix_valid = sync_pix;
        pix_luma = 8'hFF;
        @(negedge clk);
        line_start = 1'b0;
        pix_valid = 1'b0;
      end
      if (mid_sw && y == 3) map_sel = ~2'(sel);
      for (int x = 0; x < GS + extra; x++) begin
        if (gaps && (x % 5 == 2)) begin
          pix_valid = 1'b0;
          pix_luma = 8'hFF;
          @(negedge clk);
        end
        pix_valid = 1'b1;
        if (x < GS) begin
          lv = luma_of(kind, prm, x, y);
          w = wt(sel, y / ZH, x / ZW);
          msum += longint'(lv * w);
          mw += longint'(w);
        end else begin
          lv = 255;
        end
        pix_luma = 8'(lv);
        @(negedge clk);
      end
      pix_valid = 1'b0;
    end
  endtask

  task automatic wait_result(output int val, output int pulses);
    val = -1;
    pulses = 0;
    for (int i = 0; i < 60; i++) begin
      if (meas_valid) begin
        pulses++;
        val = int'(meas);
      end
      @(negedge clk);
    end
  endtask

  function automatic int model_result();
    longint r;
    r = (msum * 16) / mw;
    return (r > 4095) ? 4095 : int'(r);
  endfunction

  task automatic frame_check(input int sel, input int kind, input int prm, input int expc,
                             input string tag, input int extra, input bit lead_ls,
                             input bit mid_sw, input bit gaps, input bit sync_pix);
    int val;
    int pulses;
    int exp_v;
    drive_frame(sel, kind, prm, extra, lead_ls, mid_sw, gaps, sync_pix);
    exp_v = (expc == int'(USE_MODEL)) ? model_result() : expc;
    wait_result(val, pulses);
    check(pulses == 1, "R5 one pulse per frame", pulses, 1);
    check(val == exp_v, tag, val, exp_v);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int val;
    int pulses;
    repeat (4) @(negedge clk);
    check(meas == 12'd0, "R1 meas in reset", int'(meas), 0);
    check(meas_valid == 1'b0, "R1 valid in reset", int'(meas_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(meas == 12'd0 && !meas_valid, "R1 after reset", int'(meas), 0);

    // Vector table: R3 map shapes and R4 arithmetic
    for (int i = 0; i < NV; i++) begin
      frame_check(int'(VEC[i][25:24]), int'(VEC[i][23:21]), int'(VEC[i][20:13]),
                  int'(VEC[i][12:0]), "R3/R4 vector", 0, 1'b0, 1'b0, 1'b0, 1'b0);
    end

    // R5: result holds between pulses
    val = int'(meas);
    repeat (15) @(negedge clk);
    check(int'(meas) == val && !meas_valid, "R5 hold", int'(meas), val);

    // R6: map change mid-frame has no effect
    frame_check(3, 2, 0, 2550, "R6 mid-frame map change", 0, 1'b0, 1'b1, 1'b0, 1'b0);

    // R2: bright pixels beyond the right edge are ignored
    frame_check(0, 3, 0, 1511, "R2 out-of-grid pixels", 3, 1'b0, 1'b0, 1'b0, 1'b0);

    // R8 and R9: leading line strobe, stalled pixel stream
    frame_check(2, 0, 77, 1232, "R8/R9 lead strobe and gaps", 0, 1'b1, 1'b0, 1'b1, 1'b0);

    // R7: aborted partial frame, then pixels riding on sync strobes
    map_sel = 2'b10;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int x = 0; x < 40; x++) begin
      pix_valid = 1'b1;
      pix_luma = 8'hFF;
      @(negedge clk);
    end
    pix_valid = 1'b0;
    wait_result(val, pulses);
    check(pulses == 0, "R7 no result for partial frame", pulses, 0);
    frame_check(2, 0, 50, 800, "R7 restart and sync pixels", 0, 1'b0, 1'b0, 1'b0, 1'b1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule